// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Control Model

This block is a synthesizable behavioural model of the control logic in a byte-wide, one-time-programmable memory. It is meant to stand in for such a memory inside a testbench. The electrical conditions of the real part are reduced to digital flags:

- an active-low chip select and an active-low output enable;
- a flag that says programming voltage is present;
- a flag that says the programming supply is raised;
- a flag for a high voltage on the identifier address line;
- a flag that tells a CMOS-level deselect apart from a TTL-level one.

From these inputs the block decodes one of eight modes. It returns stored bytes, fixed identifier codes, or nothing at all.

The storage is a small array sized by a parameter. After reset every bit of the array is one. Programming can only move bits from one to zero, because each write ANDs the incoming byte into the stored byte.

Every output is registered. Each output reflects the inputs sampled at the previous rising clock edge, so the block adds one cycle of latency. A data-enable output marks the cycles in which the model would drive its data pins; a wrapper can use it to build a tri-state bus. Access-time delays are not modelled.

Top module: `otp_mode_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become mode 2, data-enable 0 and data 0x00, and every array byte becomes 0xFF.
- R2: With `chip_sel_n` high and `prog_volt` low, the mode is 3 when `desel_cmos` is 1 and 2 otherwise. In both cases data-enable and data are 0, whatever `out_en_n` is.
- R3: With `chip_sel_n`, `out_en_n`, `prog_volt`, `id_hv` and `vcc_prog` all low, the mode is 0 (read), data-enable is 1 and the data is the stored byte at `addr`.
- R4: With `chip_sel_n` low, `out_en_n` high and `prog_volt` low, the mode is 1 (output off), and data-enable and data are 0.
- R5: With `chip_sel_n` low and `prog_volt` high, the mode is 4 (program), whatever `id_hv` is. The byte at `addr` becomes the old byte AND `din`, and data-enable is 0.
- R6: With `chip_sel_n` high and `prog_volt` high, the mode is 6 (inhibit). No byte changes and data-enable is 0.
- R7: With the read conditions of R3 but `vcc_prog` high, the mode is 5 (verify), data-enable is 1 and the data is the stored byte at `addr`.
- R8: With `chip_sel_n` and `out_en_n` low, `prog_volt` low and `id_hv` high, the mode is 7 (identify). When `addr[1]` is 1, the data is 0x1C if `addr[0]` is 0 and 0x83 if `addr[0]` is 1.
- R9: In identify mode with `addr[1]` at 0, the data is 0x7F for both values of `addr[0]`.
- R10: Every byte returned in identify mode has odd parity, with bit 7 acting as the parity bit.
- R11: The outputs change only at a rising clock edge, and they reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel_n | input | 1 | Device select, active low |
| out_en_n | input | 1 | Output enable, active low |
| prog_volt | input | 1 | Programming voltage present |
| vcc_prog | input | 1 | Programming supply level raised (turns a read into a verify) |
| id_hv | input | 1 | High voltage on the identifier address line |
| desel_cmos | input | 1 | Deselect is at CMOS level (1) or TTL level (0) |
| addr | input | $clog2(DEPTH) | Byte address; bits 1 and 0 select the identifier byte |
| din | input | 8 | Byte to program |
| dout | output | 8 | Registered read data, 0 when not driven |
| dout_en | output | 1 | Registered data-pin drive enable |
| mode | output | 3 | Registered decoded mode: 0 read, 1 output off, 2 TTL standby, 3 CMOS standby, 4 program, 5 verify, 6 inhibit, 7 identify |

## Verification
The assertions assume that every control flag and the address are synchronous to `clk`, stay stable around the rising edge, and are never X once reset is released. They also assume that `DEPTH` is a power of two of at least 4, so that any value on `addr` names a real byte and the two identifier select bits exist. The stimulus changes its inputs only on the falling edge and draws addresses inside the array. Random cycles are biased towards a small address window, so that repeated programming and reads of the same bytes occur often.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    M_READ      = 3'd0,
    M_OUTOFF    = 3'd1,
    M_STBY_TTL  = 3'd2,
    M_STBY_CMOS = 3'd3,
    M_PROG      = 3'd4,
    M_VERIFY    = 3'd5,
    M_INHIBIT   = 3'd6,
    M_IDENT     = 3'd7
  } otp_mode_e;

  localparam logic [BYTE_W-1:0] ID_MAKER = 8'h1C;
  localparam logic [BYTE_W-1:0] ID_PART  = 8'h83;
  localparam logic [BYTE_W-1:0] ID_CONT  = 8'h7F;
  localparam logic [BYTE_W-1:0] ERASED   = {BYTE_W{1'b1}};

  function automatic logic drives_bus(input otp_mode_e m);
    return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp,
  input  logic      vcc_hi,
  input  logic      hv_id,
  input  logic      cmos_lvl,
  output otp_mode_e mode_n
);

  always_comb begin
    if (ce_n) begin
      if (vpp)           mode_n = M_INHIBIT;
      else if (cmos_lvl) mode_n = M_STBY_CMOS;
      else               mode_n = M_STBY_TTL;
    end else if (vpp) begin
      mode_n = M_PROG;
    end else if (oe_n) begin
      mode_n = M_OUTOFF;
    end else if (hv_id) begin
      mode_n = M_IDENT;
    end else if (vcc_hi) begin
      mode_n = M_VERIFY;
    end else begin
      mode_n = M_READ;
    end
  end

endmodule

// File: rtl/otp_id_select.sv
module otp_id_select
  import otp_pkg::*;
(
  input  logic              sel_hi,
  input  logic              sel_lo,
  output logic [BYTE_W-1:0] code
);

  always_comb begin
    if (!sel_hi)     code = ID_CONT;
    else if (sel_lo) code = ID_PART;
    else             code = ID_MAKER;
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] mem_q [DEPTH];

  assign rdata = mem_q[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (we) begin
      mem_q[addr] <= mem_q[addr] & wdata;
    end
  end

  // R5: a program cycle leaves the old byte ANDed with the written byte
  a_r5_and_write: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem_q[$past(addr)] == ($past(rdata) & $past(wdata))));

  // R5: a program cycle never sets a bit
  a_r5_no_set: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem_q[$past(addr)] & ~$past(rdata)) == '0));

endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              prog_volt,
  input  logic              vcc_prog,
  input  logic              id_hv,
  input  logic              desel_cmos,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en,
  output logic [2:0]        mode
);

  otp_mode_e         mode_n, mode_q;
  logic [BYTE_W-1:0] cell_data;
  logic [BYTE_W-1:0] id_code;
  logic              wr_en;

  otp_mode_decode u_decode (
    .ce_n     (chip_sel_n),
    .oe_n     (out_en_n),
    .vpp      (prog_volt),
    .vcc_hi   (vcc_prog),
    .hv_id    (id_hv),
    .cmos_lvl (desel_cmos),
    .mode_n   (mode_n)
  );

  assign wr_en = (mode_n == M_PROG);

  otp_cell_array #(.DEPTH(DEPTH)) u_cells (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .addr  (addr),
    .wdata (din),
    .rdata (cell_data)
  );

  otp_id_select u_ident (
    .sel_hi (addr[1]),
    .sel_lo (addr[0]),
    .code   (id_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_STBY_TTL;
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      mode_q  <= mode_n;
      dout_en <= drives_bus(mode_n);
      case (mode_n)
        M_READ, M_VERIFY: dout <= cell_data;
        M_IDENT:          dout <= id_code;
        default:          dout <= '0;
      endcase
    end
  end

  assign mode = mode_q;

  // R2: a deselected device never drives its data pins
  a_r2_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(chip_sel_n)) |-> (!dout_en && dout == '0));

  // R3: a plain read condition enables the data pins one cycle later
  a_r3_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!chip_sel_n && !out_en_n && !prog_volt)) |-> dout_en);

  // R5 / R6: programming voltage always keeps the data pins off
  a_r6_vpp_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(prog_volt)) |-> !dout_en);

  // R10: identify bytes carry odd parity
  a_r10_odd_parity: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd7) |-> (^dout));

endmodule

// File: tb/otp_mode_ctrl_tb.sv
module otp_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int AW         = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst;
  logic          chip_sel_n, out_en_n, prog_volt, vcc_prog, id_hv, desel_cmos;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          dout_en;
  logic [2:0]    mode;

  int   checks   = 0;
  int   failures = 0;
  bit   finished = 0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_mode_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .prog_volt(prog_volt), .vcc_prog(vcc_prog), .id_hv(id_hv),
    .desel_cmos(desel_cmos), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .mode(mode)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mode(input logic ce_n, oe_n, vpp, vhi,
                                          hv, cm);
    if (ce_n) return vpp ? 3'd6 : (cm ? 3'd3 : 3'd2);
    if (vpp)  return 3'd4;
    if (oe_n) return 3'd1;
    if (hv)   return 3'd7;
    return vhi ? 3'd5 : 3'd0;
  endfunction

  function automatic logic [7:0] exp_id(input logic [AW-1:0] a);
    if (!a[1]) return 8'h7F;
    return a[0] ? 8'h83 : 8'h1C;
  endfunction

  function automatic string tag_of(input logic [2:0] m, input logic [AW-1:0] a);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R2";
      3'd4: return "R5";
      3'd5: return "R7";
      3'd6: return "R6";
      default: return a[1] ? "R8" : "R9";
    endcase
  endfunction

  // apply inputs after a falling edge, let one rising edge pass, check
  task automatic step(input logic ce_n, oe_n, vpp, vhi, hv, cm,
                      input logic [AW-1:0] a, input logic [7:0] d);
    logic [2:0] em;
    logic       een;
    logic [7:0] ed;
    string      tg;
    chip_sel_n = ce_n; out_en_n = oe_n; prog_volt = vpp; vcc_prog = vhi;
    id_hv = hv; desel_cmos = cm; addr = a; din = d;
    em  = exp_mode(ce_n, oe_n, vpp, vhi, hv, cm);
    een = (em == 3'd0) || (em == 3'd5) || (em == 3'd7);
    ed  = (em == 3'd7) ? exp_id(a) : (een ? model[a] : 8'h00);
    if (em == 3'd4) model[a] = model[a] & d;
    tg  = tag_of(em, a);
    @(posedge clk);
    @(negedge clk);
    chk(mode == em, tg, "mode", int'(mode), int'(em));
    chk(dout_en == een, tg, "dout_en", int'(dout_en), int'(een));
    chk(dout == ed, tg, "dout", int'(dout), int'(ed));
    if (em == 3'd7) chk(^dout == 1'b1, "R10", "parity", int'(^dout), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    rst = 1'b1; chip_sel_n = 1'b0; out_en_n = 1'b0; prog_volt = 1'b0;
    vcc_prog = 1'b0; id_hv = 1'b0; desel_cmos = 1'b0; addr = '0; din = '0;
    @(negedge clk); @(negedge clk);
    // R1: reset state of the registered outputs
    chk(mode == 3'd2, "R1", "reset mode", int'(mode), 2);
    chk(dout_en == 1'b0, "R1", "reset dout_en", int'(dout_en), 0);
    chk(dout == 8'h00, "R1", "reset dout", int'(dout), 0);
    rst = 1'b0;
    // R1: whole array erased, observed through reads
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 0, 0, 0, 0, 0, AW'(a), 8'h00);
      chk(dout == 8'hFF, "R1", "erased byte", int'(dout), 8'hFF);
    end
    // R2: both standby levels, output enable ignored
    step(1, 0, 0, 0, 0, 0, AW'(5), 8'h00);
    step(1, 0, 0, 0, 0, 1, AW'(5), 8'h00);
    step(1, 1, 0, 0, 1, 1, AW'(5), 8'h00);
    // R4: output off
    step(0, 1, 0, 0, 0, 0, AW'(5), 8'h00);
    // R5: two programs AND together, then read back
    step(0, 0, 1, 1, 0, 0, AW'(9), 8'hF0);
    step(0, 0, 1, 1, 1, 0, AW'(9), 8'h3C);
    step(0, 0, 0, 0, 0, 0, AW'(9), 8'h00);
    chk(dout == 8'h30, "R5", "ANDed byte", int'(dout), 8'h30);
    // R5: writing ones cannot restore cleared bits
    step(0, 0, 1, 0, 0, 0, AW'(9), 8'hFF);
    step(0, 0, 0, 1, 0, 0, AW'(9), 8'h00);
    chk(dout == 8'h30, "R7", "verify after ones write", int'(dout), 8'h30);
    // R6: inhibit leaves the byte untouched
    step(1, 0, 1, 1, 0, 0, AW'(9), 8'h00);
    step(0, 0, 0, 0, 0, 0, AW'(9), 8'h00);
    chk(dout == 8'h30, "R6", "byte after inhibit", int'(dout), 8'h30);
    // R8, R9, R10: all identifier selections
    for (int s = 0; s < 4; s++) step(0, 0, 0, 0, 1, 0, AW'(s), 8'h00);
    step(0, 0, 0, 1, 1, 0, AW'(2), 8'h00);
    chk(dout == 8'h1C, "R8", "maker code", int'(dout), 8'h1C);
    step(0, 0, 0, 0, 1, 0, AW'(3), 8'h00);
    chk(dout == 8'h83, "R8", "part code", int'(dout), 8'h83);
    // R11: outputs hold until the next rising edge
    step(0, 0, 0, 0, 0, 0, AW'(9), 8'h00);
    chip_sel_n = 1'b1;
    #(CLK_PERIOD/4);
    chk(dout_en == 1'b1, "R11", "held dout_en", int'(dout_en), 1);
    chk(dout == 8'h30, "R11", "held dout", int'(dout), 8'h30);
    step(1, 0, 0, 0, 0, 0, AW'(9), 8'h00);
    chk(dout_en == 1'b0, "R11", "dout_en after edge", int'(dout_en), 0);
    // random traffic, biased to a small address window
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] ra;
      ra = ($urandom % 2 == 0) ? AW'($urandom % 8) : AW'($urandom);
      step(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0, ($urandom % 5) == 0, $urandom % 2,
           ra, 8'($urandom));
    end
    // R1: reset restores the erased array
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    step(0, 0, 0, 0, 0, 0, AW'(9), 8'h00);
    chk(dout == 8'hFF, "R1", "byte after re-reset", int'(dout), 8'hFF);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule